// File: doc/BRIEF.md
# Integer ALU with population counts

This block is the arithmetic execution unit of a 32-bit integer core. It takes a 4-bit operation code, two operands and a 16-bit immediate. Every operation except the random source is purely combinational, and the result, carry and zero outputs settle in the same cycle. When `use_imm` is high, the zero-extended immediate takes the place of the second operand. This serves the register-immediate instruction form.

The operations are add, subtract, multiply (a build-time option, present by default), logical shifts and rotates. There are three bit-population counts: ones, zeros, and changes between neighbouring bits. A random-number operation returns the state of an internal 32-bit linear feedback shift register. That register is the only clocked state in the block. It moves one step on each clock edge where `exec_en` is high with the random operation selected.

Top module: `int_alu`

## Requirements
- R1: Code 0x0 (add) returns A+B modulo 2^32, with `carry` set to the carry-out of bit 31.
- R2: Code 0x1 (subtract) returns A-B modulo 2^32. `carry` is 1 when no borrow occurs, that is, when A >= B unsigned.
- R3: When `use_imm` is 1, `imm16` is zero-extended to 32 bits and used as B, and `opnd_b` is ignored.
- R4: Code 0x2 (multiply, with HAS_MUL=1) returns the low 32 bits of A*B.
- R5: Code 0x3 is a logical right shift and code 0x4 a logical left shift of A. The shift amount is B[4:0], and the other bits of B are ignored.
- R6: Code 0x5 rotates A right and code 0x6 rotates A left, each by B[4:0] positions.
- R7: Code 0x7 returns the number of 1 bits in A, and code 0x8 returns the number of 0 bits in A (0 to 32).
- R8: Code 0x9 returns the count of positions i in 0..30 where A[i] differs from A[i+1].
- R9: Code 0xA returns the state of a 32-bit Galois LFSR. The state is shifted right and XORed with 0x80200003 when the bit shifted out is 1. Reset loads RND_SEED (default 0x1D2C3B4A). The state advances only on a clock edge with `exec_en`=1 and code 0xA.
- R10: Codes 0xB to 0xF return 0 with `carry` 0.
- R11: `zero` is 1 exactly when `result` is all zeros, for every code.
- R12: `carry` is 0 for every code other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the random-number state |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | The operation is issued this cycle (advances the random source when code is 0xA) |
| alu_op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second register operand |
| use_imm | input | 1 | Select the immediate as the second operand |
| imm16 | input | 16 | Immediate value, zero-extended |
| result | output | 32 | Operation result |
| carry | output | 1 | Carry of add, no-borrow of subtract, else 0 |
| zero | output | 1 | Result is all zeros |

## Verification
The assertions check five things on every cycle. The random state never becomes zero. It holds unless a random operation is issued, and it changes when one is. Rotations keep the number of ones in A. The no-borrow flag of subtract agrees with an unsigned comparison. The arithmetic values, the field selection of shift amounts, the immediate's zero extension, the transition count on chosen patterns and the exact random sequence after reset can only be shown by the bench's directed scenarios. So can the quiet unused codes.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int          DATA_W   = 32,
  parameter int          IMM_W    = 16,
  parameter bit          HAS_MUL  = 1'b1,
  parameter logic [31:0] RND_SEED = 32'h1D2C_3B4A,
  parameter logic [31:0] RND_TAPS = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        alu_op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm16,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              zero
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int CNT_W = $clog2(DATA_W + 1);

  function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [DATA_W-1:0]   b_eff, mul_res, lfsr_q, trans;
  logic [DATA_W:0]     sum, diff;
  logic [2*DATA_W-1:0] ror_w, rol_w;
  logic [SH_W-1:0]     shamt;
  logic [CNT_W-1:0]    cnt_one, cnt_trn;
  logic                rnd_fire;

  assign b_eff   = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm16} : opnd_b;
  assign sum     = {1'b0, opnd_a} + {1'b0, b_eff};
  assign diff    = {1'b0, opnd_a} - {1'b0, b_eff};
  assign shamt   = b_eff[SH_W-1:0];
  assign ror_w   = {opnd_a, opnd_a} >> shamt;
  assign rol_w   = {opnd_a, opnd_a} << shamt;
  assign trans   = {1'b0, opnd_a[DATA_W-2:0] ^ opnd_a[DATA_W-1:1]};
  assign cnt_one = ones(opnd_a);
  assign cnt_trn = ones(trans);

  generate
    if (HAS_MUL) begin : g_mul
      assign mul_res = opnd_a * b_eff;
    end else begin : g_nomul
      assign mul_res = '0;
    end
  endgenerate

  always_comb begin
    carry = 1'b0;
    case (alu_op)
      4'h0: begin result = sum[DATA_W-1:0];  carry = sum[DATA_W];   end
      4'h1: begin result = diff[DATA_W-1:0]; carry = ~diff[DATA_W]; end
      4'h2: result = mul_res;
      4'h3: result = opnd_a >> shamt;
      4'h4: result = opnd_a << shamt;
      4'h5: result = ror_w[DATA_W-1:0];
      4'h6: result = rol_w[2*DATA_W-1:DATA_W];
      4'h7: result = DATA_W'(cnt_one);
      4'h8: result = DATA_W'(CNT_W'(DATA_W) - cnt_one);
      4'h9: result = DATA_W'(cnt_trn);
      4'hA: result = lfsr_q;
      default: result = '0;
    endcase
  end

  assign zero = ~|result;

  assign rnd_fire = exec_en && (alu_op == 4'hA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lfsr_q <= RND_SEED;
    else if (rnd_fire) lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? RND_TAPS : '0);

  AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);                                                          // R9
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd_fire |=> $stable(lfsr_q));                                         // R9
  AST_RND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_fire |=> lfsr_q != $past(lfsr_q));                                  // R9
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 4'h5 || alu_op == 4'h6) |-> $countones(result) == $countones(opnd_a)); // R6
  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 4'h1) |-> carry == (opnd_a >= b_eff));                       // R2
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  logic        clk = 1'b0, rst_n = 1'b0, exec_en = 1'b0, use_imm = 1'b0;
  logic [3:0]  alu_op = 4'h0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] result;
  logic        carry, zero;
  int checks = 0, errors = 0;

  localparam logic [31:0] SEED = 32'h1D2C_3B4A;

  always #2.5 clk = ~clk;

  int_alu uut (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .alu_op(alu_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .use_imm(use_imm), .imm16(imm16),
    .result(result), .carry(carry), .zero(zero));

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic imm_sel, input logic [15:0] imm,
                     input logic [31:0] exp_r, input logic exp_c);
    @(negedge clk);
    alu_op = op; opnd_a = a; opnd_b = b; use_imm = imm_sel; imm16 = imm;
    #1;
    chk(req, result, exp_r);
    chk({req, " carry"}, {31'b0, carry}, {31'b0, exp_c});
    chk("R11 zero", {31'b0, zero}, {31'b0, exp_r == 32'h0});
  endtask

  task automatic t_add_sub;
    run("R1 add", 4'h0, 32'h1234_5678, 32'h1111_1111, 0, 0, 32'h2345_6789, 0);
    run("R1 add wrap", 4'h0, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h0, 1);
    run("R2 sub", 4'h1, 32'd5, 32'd3, 0, 0, 32'd2, 1);
    run("R2 sub borrow", 4'h1, 32'd3, 32'd5, 0, 0, 32'hFFFF_FFFE, 0);
    run("R2 sub equal", 4'h1, 32'd7, 32'd7, 0, 0, 32'h0, 1);
  endtask

  task automatic t_imm;
    run("R3 imm add", 4'h0, 32'h10, 32'hDEAD_BEEF, 1, 16'hFFFF, 32'h0001_000F, 0);
    run("R3 imm sub", 4'h1, 32'h0001_0000, 32'h0, 1, 16'h8000, 32'h0000_8000, 1);
  endtask

  task automatic t_mul;
    run("R4 mul", 4'h2, 32'd7, 32'd6, 0, 0, 32'd42, 0);
    run("R4 mul trunc", 4'h2, 32'h0001_0000, 32'h0001_0001, 0, 0, 32'h0001_0000, 0);
  endtask

  task automatic t_shift_rot;
    run("R5 shr", 4'h3, 32'h8000_0000, 32'd35, 0, 0, 32'h1000_0000, 0);
    run("R5 shl", 4'h4, 32'h1, 32'd31, 0, 0, 32'h8000_0000, 0);
    run("R5 shl imm", 4'h4, 32'h3, 32'h0, 1, 16'h0024, 32'h30, 0);
    run("R6 ror", 4'h5, 32'h1, 32'd1, 0, 0, 32'h8000_0000, 0);
    run("R6 rol", 4'h6, 32'h8000_0001, 32'd4, 0, 0, 32'h18, 0);
    run("R6 ror zero", 4'h5, 32'hA5A5_0F0F, 32'd32, 0, 0, 32'hA5A5_0F0F, 0);
  endtask

  task automatic t_popcnt;
    run("R7 ones", 4'h7, 32'hF0F0_F0F0, 0, 0, 0, 32'd16, 0);
    run("R7 ones none", 4'h7, 32'h0, 0, 0, 0, 32'd0, 0);
    run("R7 zeros all", 4'h8, 32'h0, 0, 0, 0, 32'd32, 0);
    run("R7 zeros none", 4'h8, 32'hFFFF_FFFF, 0, 0, 0, 32'd0, 0);
    run("R8 trans alt", 4'h9, 32'h5555_5555, 0, 0, 0, 32'd31, 0);
    run("R8 trans one", 4'h9, 32'h1, 0, 0, 0, 32'd1, 0);
    run("R8 trans ends", 4'h9, 32'h8000_0001, 0, 0, 0, 32'd2, 0);
    run("R8 trans flat", 4'h9, 32'hFFFF_FFFF, 0, 0, 0, 32'd0, 0);
  endtask

  task automatic t_unused;
    for (int c = 11; c < 16; c++)
      run("R10 unused", 4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 32'h0, 0);
    run("R12 carry shl", 4'h4, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'hFFFF_FFFE, 0);
  endtask

  task automatic t_rnd;
    logic [31:0] st;
    st = SEED;
    run("R9 seed", 4'hA, 0, 0, 0, 0, st, 0);
    @(negedge clk); #1;
    chk("R9 hold", result, st);
    @(negedge clk);
    exec_en = 1'b1; alu_op = 4'h0;
    @(negedge clk);
    exec_en = 1'b0; alu_op = 4'hA; #1;
    chk("R9 no step other op", result, st);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      exec_en = 1'b1; alu_op = 4'hA;
      @(negedge clk);
      exec_en = 1'b0; #1;
      st = lfsr_next(st);
      chk("R9 step", result, st);
    end
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    alu_op = 4'hA; #1;
    chk("R9 seed in reset", result, SEED);
    rst_n = 1'b1;
    t_rnd();
    t_add_sub();
    t_imm();
    t_mul();
    t_shift_rot();
    t_popcnt();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule